// File: doc/BRIEF.md
# UART Line Status Tracker

This block builds and maintains the eight-bit line status word of a 16550-style serial port. The receiver hands it finished characters together with their parity, framing and break flags, plus a separate strobe that fires when the serial line has sat low for longer than one complete character frame. The block stores each character and its three flags in a receive FIFO. It keeps sticky error bits, and it tracks how many stored characters carry a flag. From that count it derives the error summary bit.

The transmit path supplies two plain occupancy levels: transmit FIFO empty and transmit shift register empty. The block registers both and turns them into the two transmit status bits. The CPU side has two parts. The first is a status read port: the status word is always visible, and a one-cycle read strobe applies clear-on-read. The second is a valid/ready pop stream that drains the receive FIFO.

The receive input has no ready signal, because a serial receiver cannot be stalled. A character that arrives while the FIFO is full is dropped and reported as an overrun. On the pop stream, `pop_valid` stays high while the FIFO holds data. A transfer happens on a cycle where both `pop_valid` and `pop_ready` are high. While `pop_ready` is low, the head entry is held unchanged. `pop_ready` has no effect while the FIFO is empty.

Top module: `uart_line_status`

## Requirements
- R1: `lsr_rdata` places the status bits as follows: bit 0 DR, bit 1 OE, bit 2 PE, bit 3 FE, bit 4 BI, bit 5 THRE, bit 6 TEMT, bit 7 ERRF. Bits 31:8 always read 0.
- R2: After reset, `lsr_rdata[7:0]` reads 0x60: TEMT=1, THRE=1 and every other bit 0.
- R3: DR is 1 exactly while the receive FIFO holds at least one character.
- R4: A character offered while the FIFO already holds RX_DEPTH entries is discarded and sets OE. The stored entries and their order stay unchanged.
- R5: An accepted character with `rx_perr` set sets PE. An accepted character with `rx_ferr` set sets FE.
- R6: BI is set by a `line_break` strobe, or by an accepted character with `rx_brk` set.
- R7: A cycle with `lsr_rd` high clears OE, PE, FE and BI at the next edge. In that cycle the read returns the values held before the edge. A set event in the same cycle as a read wins, so the bit stays 1.
- R8: ERRF is set when a flagged character (parity, framing or break) is accepted. A status read clears ERRF only if no flagged character remains in the FIFO after that cycle's push and pop. Without a read, ERRF stays 1.
- R9: THRE equals `tx_fifo_empty` sampled at the previous edge. TEMT equals `tx_fifo_empty` AND `tx_shift_empty` sampled at the previous edge.
- R10: `pop_valid` is high while the FIFO is non-empty. `pop_data` and the three `pop_*` flags show the oldest entry. An entry leaves the FIFO on a cycle with `pop_valid` and `pop_ready` both high, in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Receiver completed a character this cycle |
| rx_data | input | 8 | Received character |
| rx_perr | input | 1 | Character had a bad parity bit |
| rx_ferr | input | 1 | Character had an invalid stop bit |
| rx_brk | input | 1 | Character was part of a break condition |
| line_break | input | 1 | Line held low longer than one character frame |
| tx_fifo_empty | input | 1 | Transmit FIFO empty level |
| tx_shift_empty | input | 1 | Transmit shift register empty level |
| pop_valid | output | 1 | Receive FIFO head is valid |
| pop_ready | input | 1 | CPU takes the head entry |
| pop_data | output | 8 | Head character |
| pop_perr | output | 1 | Head parity flag |
| pop_ferr | output | 1 | Head framing flag |
| pop_brk | output | 1 | Head break flag |
| lsr_rd | input | 1 | CPU status read strobe (clear-on-read) |
| lsr_rdata | output | 32 | Status word |

## Verification
The bench instantiates the block with RX_DEPTH set to 4 instead of 16. Random receive traffic then fills the FIFO often, which reaches overrun and discard-on-full within a few cycles. It also creates many cases where a flagged character is still stored when a status read arrives, and cases where it was popped just before. The shallow FIFO also makes pointer wrap frequent. That exercises the ordering of the pop stream and the rise and fall of the flagged-entry count many times per run.

// File: rtl/uls_pkg.sv
package uls_pkg;
  localparam int DATA_W = 8;
  localparam int LSR_W  = 32;

  // status word bit positions
  localparam int LB_DR   = 0;
  localparam int LB_OE   = 1;
  localparam int LB_PE   = 2;
  localparam int LB_FE   = 3;
  localparam int LB_BI   = 4;
  localparam int LB_THRE = 5;
  localparam int LB_TEMT = 6;
  localparam int LB_ERRF = 7;

  // sticky flag vector positions
  localparam int SF_OE = 0;
  localparam int SF_PE = 1;
  localparam int SF_FE = 2;
  localparam int SF_BI = 3;
  localparam int SF_W  = 4;

  typedef struct packed {
    logic              brk;
    logic              ferr;
    logic              perr;
    logic [DATA_W-1:0] data;
  } rx_entry_t;

  function automatic logic entry_flagged(rx_entry_t e);
    return e.brk | e.ferr | e.perr;
  endfunction
endpackage

// File: rtl/uls_rx_fifo.sv
module uls_rx_fifo
  import uls_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      in_valid,
  input  rx_entry_t in_entry,
  output logic      in_accept,
  output logic      in_overrun,
  output logic      out_valid,
  input  logic      out_ready,
  output rx_entry_t out_entry,
  output logic      out_fire
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  rx_entry_t     mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          full;

  function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign full       = (count == CW'(DEPTH));
  assign in_accept  = in_valid & ~full;
  assign in_overrun = in_valid & full;
  assign out_valid  = (count != '0);
  assign out_fire   = out_valid & out_ready;
  assign out_entry  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (in_accept) mem[wr_ptr] <= in_entry;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (in_accept) wr_ptr <= bump(wr_ptr);
      if (out_fire)  rd_ptr <= bump(rd_ptr);
      count <= count + CW'(in_accept) - CW'(out_fire);
    end
  end

  // R4: a full FIFO refuses the write, so occupancy never grows past DEPTH
  a_r4_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !out_ready) |=> (count == CW'(DEPTH)));

  // R10: a stalled head stays valid and unchanged
  a_r10_head_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_entry)));

  a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
endmodule

// File: rtl/uls_sticky_bits.sv
module uls_sticky_bits #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic         clr,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) q[i] <= 1'b0;
      else        q[i] <= set[i] | (q[i] & ~clr);
    end

    // R7: a set arriving with a read is not lost
    a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set[i] |=> q[i]);

    // R7: a read with no set event clears the bit
    a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !set[i]) |=> !q[i]);
  end
endmodule

// File: rtl/uls_err_tracker.sv
module uls_err_tracker #(
  parameter int DEPTH = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic dec,
  input  logic rd,
  output logic errf
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] cnt, cnt_d;
  logic          errf_d;

  always_comb begin
    cnt_d  = cnt + CW'(inc) - CW'(dec);
    errf_d = inc | (errf & ~(rd & (cnt_d == '0)));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      errf <= 1'b0;
    end else begin
      cnt  <= cnt_d;
      errf <= errf_d;
    end
  end

  // R8: summary bit is up whenever a flagged entry is stored
  a_r8_errf_covers_cnt: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |-> errf);

  a_r8_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

  // R8: no read means no clear
  a_r8_sticky_without_read: assert property (@(posedge clk) disable iff (!rst_n)
    (errf && !rd) |=> errf);
endmodule

// File: rtl/uart_line_status.sv
module uart_line_status
  import uls_pkg::*;
#(
  parameter int RX_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_perr,
  input  logic              rx_ferr,
  input  logic              rx_brk,
  input  logic              line_break,
  input  logic              tx_fifo_empty,
  input  logic              tx_shift_empty,
  output logic              pop_valid,
  input  logic              pop_ready,
  output logic [DATA_W-1:0] pop_data,
  output logic              pop_perr,
  output logic              pop_ferr,
  output logic              pop_brk,
  input  logic              lsr_rd,
  output logic [LSR_W-1:0]  lsr_rdata
);
  rx_entry_t         in_entry, head;
  logic              accept, overrun, fire;
  logic [SF_W-1:0]   sticky_set, sticky_q;
  logic              errf;
  logic              thre_q, temt_q;

  assign in_entry = '{brk: rx_brk, ferr: rx_ferr, perr: rx_perr, data: rx_data};

  uls_rx_fifo #(.DEPTH(RX_DEPTH)) u_fifo (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (rx_valid),
    .in_entry   (in_entry),
    .in_accept  (accept),
    .in_overrun (overrun),
    .out_valid  (pop_valid),
    .out_ready  (pop_ready),
    .out_entry  (head),
    .out_fire   (fire)
  );

  assign pop_data = head.data;
  assign pop_perr = head.perr;
  assign pop_ferr = head.ferr;
  assign pop_brk  = head.brk;

  always_comb begin
    sticky_set        = '0;
    sticky_set[SF_OE] = overrun;
    sticky_set[SF_PE] = accept & rx_perr;
    sticky_set[SF_FE] = accept & rx_ferr;
    sticky_set[SF_BI] = line_break | (accept & rx_brk);
  end

  uls_sticky_bits #(.W(SF_W)) u_sticky (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (sticky_set),
    .clr   (lsr_rd),
    .q     (sticky_q)
  );

  uls_err_tracker #(.DEPTH(RX_DEPTH)) u_err (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (accept & entry_flagged(in_entry)),
    .dec   (fire & entry_flagged(head)),
    .rd    (lsr_rd),
    .errf  (errf)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thre_q <= 1'b1;
      temt_q <= 1'b1;
    end else begin
      thre_q <= tx_fifo_empty;
      temt_q <= tx_fifo_empty & tx_shift_empty;
    end
  end

  always_comb begin
    lsr_rdata          = '0;
    lsr_rdata[LB_DR]   = pop_valid;
    lsr_rdata[LB_OE]   = sticky_q[SF_OE];
    lsr_rdata[LB_PE]   = sticky_q[SF_PE];
    lsr_rdata[LB_FE]   = sticky_q[SF_FE];
    lsr_rdata[LB_BI]   = sticky_q[SF_BI];
    lsr_rdata[LB_THRE] = thre_q;
    lsr_rdata[LB_TEMT] = temt_q;
    lsr_rdata[LB_ERRF] = errf;
  end

  // R9: shift register cannot be idle-reported empty while the FIFO holds data
  a_r9_temt_needs_thre: assert property (@(posedge clk) disable iff (!rst_n)
    temt_q |-> thre_q);

  // R4: an overrun leaves OE raised on the following cycle
  a_r4_overrun_flags: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> lsr_rdata[LB_OE]);

  // R8: a flagged character that is stored raises ERRF
  a_r8_flagged_push: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (rx_perr || rx_ferr || rx_brk)) |=> lsr_rdata[LB_ERRF]);

  // R1: upper bits are zero
  a_r1_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    lsr_rdata[LSR_W-1:8] == '0);
endmodule

// File: tb/uart_line_status_tb_top.sv
module uart_line_status_tb_top;
  localparam int D = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_valid = 0, rx_perr = 0, rx_ferr = 0, rx_brk = 0, line_break = 0;
  logic [7:0] rx_data = '0;
  logic tx_fifo_empty = 1, tx_shift_empty = 1, pop_ready = 0, lsr_rd = 0;
  logic pop_valid, pop_perr, pop_ferr, pop_brk;
  logic [7:0] pop_data;
  logic [31:0] lsr_rdata;

  always #4 clk = ~clk;

  uart_line_status #(.RX_DEPTH(D)) dut_i (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_brk(rx_brk),
    .line_break(line_break), .tx_fifo_empty(tx_fifo_empty),
    .tx_shift_empty(tx_shift_empty), .pop_valid(pop_valid),
    .pop_ready(pop_ready), .pop_data(pop_data), .pop_perr(pop_perr),
    .pop_ferr(pop_ferr), .pop_brk(pop_brk), .lsr_rd(lsr_rd),
    .lsr_rdata(lsr_rdata)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  // reference model state, entries packed as {brk, ferr, perr, data}
  logic [10:0] mq[$];
  logic m_oe = 0, m_pe = 0, m_fe = 0, m_bi = 0, m_errf = 0;
  logic m_thre = 1, m_temt = 1;
  logic rd_prev = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int flagged_count();
    int c = 0;
    foreach (mq[i]) if (mq[i][10:8] != 3'b000) c++;
    return c;
  endfunction

  task automatic step(input logic v, input logic [7:0] d, input logic pe,
                      input logic fe, input logic bk, input logic lb,
                      input logic pr, input logic rd, input logic txe,
                      input logic tse);
    logic full, acc;
    @(negedge clk);
    rx_valid = v; rx_data = d; rx_perr = pe; rx_ferr = fe; rx_brk = bk;
    line_break = lb; pop_ready = pr; lsr_rd = rd;
    tx_fifo_empty = txe; tx_shift_empty = tse;
    #1;
    chk("R1 upper bits", {8'h0, lsr_rdata[31:8]}, 32'h0);
    chk("R3 DR", lsr_rdata[0], mq.size() != 0);
    chk(rd_prev ? "R4/R7 OE" : "R4 OE", lsr_rdata[1], m_oe);
    chk(rd_prev ? "R5/R7 PE" : "R5 PE", lsr_rdata[2], m_pe);
    chk(rd_prev ? "R5/R7 FE" : "R5 FE", lsr_rdata[3], m_fe);
    chk(rd_prev ? "R6/R7 BI" : "R6 BI", lsr_rdata[4], m_bi);
    chk("R9 THRE", lsr_rdata[5], m_thre);
    chk("R9 TEMT", lsr_rdata[6], m_temt);
    chk("R8 ERRF", lsr_rdata[7], m_errf);
    chk("R10 pop_valid", pop_valid, mq.size() != 0);
    if (mq.size() != 0)
      chk("R10/R4 head entry", {pop_brk, pop_ferr, pop_perr, pop_data}, mq[0]);
    // model update for the coming edge
    full = (mq.size() == D);
    acc  = v && !full;
    m_oe = (v && full) | (m_oe & !rd);
    m_pe = (acc && pe) | (m_pe & !rd);
    m_fe = (acc && fe) | (m_fe & !rd);
    m_bi = lb | (acc && bk) | (m_bi & !rd);
    if (pr && mq.size() != 0) void'(mq.pop_front());
    if (acc) mq.push_back({bk, fe, pe, d});
    m_errf = (acc && (pe | fe | bk)) | (m_errf & !(rd && flagged_count() == 0));
    m_thre = txe;
    m_temt = txe & tse;
    rd_prev = rd;
  endtask

  initial begin
    #800000;
    if (!finished) begin
      n_fail++;
      $display("FAIL R10 watchdog: actual hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(1234);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R2 reset value", {24'h0, lsr_rdata[7:0]}, 32'h60);
    chk("R10 reset empty", pop_valid, 0);

    // R4: fill to depth, then overrun with a distinct byte
    for (int i = 0; i < D; i++) step(1, 8'h10 + 8'(i), 0, 0, 0, 0, 0, 0, 1, 1);
    step(1, 8'hEE, 1, 1, 1, 0, 0, 0, 1, 1);
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, 1);
    // R7: overrun and read in the same cycle, set wins
    step(1, 8'hEF, 0, 0, 0, 0, 0, 1, 1, 1);
    step(0, 0, 0, 0, 0, 0, 0, 1, 1, 1);
    for (int i = 0; i < D + 1; i++) step(0, 0, 0, 0, 0, 0, 1, 0, 0, 1);

    // R8: flagged entry then clean entry, read while flagged one is stored
    step(1, 8'hA1, 1, 0, 0, 0, 0, 0, 1, 0);
    step(1, 8'hA2, 0, 0, 0, 0, 0, 1, 1, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    step(0, 0, 0, 0, 0, 0, 1, 0, 1, 1);
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, 1);
    step(0, 0, 0, 0, 0, 0, 0, 1, 1, 1);
    step(0, 0, 0, 0, 0, 0, 1, 0, 1, 1);
    // R6: break strobe alone, with a read in the same cycle
    step(0, 0, 0, 0, 0, 1, 0, 1, 1, 1);
    step(0, 0, 0, 0, 0, 0, 0, 1, 1, 1);
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, 1);

    // constrained random traffic
    for (int n = 0; n < 4000; n++) begin
      logic v, pe, fe, bk, lb, pr, rd, txe, tse;
      v   = ($urandom % 100) < 45;
      pe  = ($urandom % 100) < 12;
      fe  = ($urandom % 100) < 12;
      bk  = ($urandom % 100) < 8;
      lb  = ($urandom % 100) < 4;
      pr  = ($urandom % 100) < 35;
      rd  = ($urandom % 100) < 20;
      txe = ($urandom % 100) < 60;
      tse = ($urandom % 100) < 60;
      step(v, 8'($urandom), pe, fe, bk, lb, pr, rd, txe, tse);
    end
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, 1);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule